// File: doc/BRIEF.md
# Sticky interrupt status register

This block gathers eight interrupt request lines into one 8-bit status register that software polls or services over a simple register bus. Each line feeds its own sticky status bit. Through a companion enable register, software selects which lines may raise their bits. Through a mode register, software decides per line whether a bit is raised by a rising edge of the line (edge mode) or on every cycle the line is high (level mode). Reading the status register hands back its contents and clears it. The exception is a level-mode bit whose line is still high: that bit stays set after the read. One interrupt output is active while any status bit is set, and a configuration input selects its polarity.

The register bus has an address, a read strobe, a write strobe, write data and read data. A read strobe captures the addressed register into the read data port, where it appears during the following cycle. Otherwise the read data port is zero. Writes take effect at the clock edge that samples the strobe. Each status bit is a two-state machine, BIT_IDLE and BIT_PEND. Its transitions are: BIT_IDLE to BIT_PEND on an enabled set event; BIT_PEND to BIT_IDLE when its enable drops, or when a status read clears it and no set event occurs in the same cycle. In every other case a bit keeps its state. The bus sequencer has two states, BUS_IDLE and BUS_RESP. Every cycle with a read strobe leads to BUS_RESP, where the captured data is driven. Every cycle without a strobe leads to BUS_IDLE.

Top module: `irq_status_regs`

## Requirements
- R1: The status register sits at address 0x07 and is read-only; a write to 0x07 changes neither the status bits nor the enable or mode registers.
- R2: Source input bit i drives status bit i. The fixed meaning of the bits, from bit 7 down to bit 0, is: transmitter sample slip, output port sample slip, sample-rate ratio out of range (either direction beyond 3), left channel over-range, right channel over-range, channel-status buffer first transfer, channel-status buffer second transfer, receiver error.
- R3: In edge mode, a 0-to-1 transition of an enabled source sets its bit, and the bit stays 1 until a status read. A source held high sets its bit only once.
- R4: A read strobe to 0x07 returns, in the next cycle, the status value present in the strobe cycle, and the bits clear at the same clock edge.
- R5: In level mode, an enabled source that is high sets its bit in every cycle, so a status read leaves that bit at 1 while the source stays high. After the source falls, the bit stays set until the next read clears it.
- R6: The enable register is at 0x08, read/write, and resets to 0x00. A 1 enables the source. A disabled source never sets its bit, and disabling a bit clears it, so it reads 0.
- R7: The mode register is at 0x09, read/write, and resets to 0x00. A 0 selects edge mode and a 1 selects level mode.
- R8: When a set event and a clearing status read fall in the same cycle, the set wins. The read returns the earlier contents, and the bit reads 1 on the following status read.
- R9: The interrupt output is asserted whenever any status bit is 1. It is high when asserted if the polarity input is 1, and low when asserted if the polarity input is 0.
- R10: After reset the status register reads 0x00 and the interrupt output is deasserted.
- R11: A read from any address other than 0x07, 0x08 or 0x09 returns 0x00, and the read data port is 0x00 in any cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle after the read strobe |
| src_in | input | 8 | Interrupt source lines, bit i feeds status bit i |
| irq_pol | input | 1 | Interrupt output polarity, 1 = active high |
| irq_out | output | 1 | Combined interrupt output |

## Verification
The two functions that can land in one cycle are the clearing status read and a new set event on the same bit. For each bit in turn, the bench raises the source at the same falling edge where it asserts the read strobe. The result is judged correct if the read returns only the earlier contents and the next read shows the bit set again. Level-mode survival is a second form of the same overlap: a source held high across the read strobe. It is judged by two reads in a row that both return the bit.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic {
        BIT_IDLE = 1'b0,
        BIT_PEND = 1'b1
    } bit_state_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

endpackage

// File: rtl/irq_sticky_cell.sv
module irq_sticky_cell
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic enable,
    input  logic level,
    input  logic clr,
    output logic pend_o
);

    bit_state_e state_q;
    bit_state_e state_nxt;
    logic       src_q;
    logic       set_evt;

    // previous source value for rising-edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= 1'b0;
        else        src_q <= src;
    end

    always_comb begin
        if (level) set_evt = enable & src;
        else       set_evt = enable & src & ~src_q;
    end

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            BIT_IDLE: begin
                if (set_evt) state_nxt = BIT_PEND;
            end
            BIT_PEND: begin
                if (!enable)              state_nxt = BIT_IDLE;
                else if (clr && !set_evt) state_nxt = BIT_IDLE;
            end
            default: state_nxt = BIT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BIT_IDLE;
        else        state_q <= state_nxt;
    end

    always_comb begin
        pend_o = (state_q == BIT_PEND);
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> (state_q == BIT_PEND)); // R8
    AST_DISABLED_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state_q == BIT_IDLE)); // R6
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BIT_PEND && enable && !clr) |=> (state_q == BIT_PEND)); // R3
    AST_LEVEL_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (level && enable && src && clr) |=> (state_q == BIT_PEND)); // R5

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
    parameter int unsigned NSRC = 8,
    parameter int unsigned AW   = 8,
    parameter logic [AW-1:0] STAT_ADDR = 8'h07,
    parameter logic [AW-1:0] MASK_ADDR = 8'h08,
    parameter logic [AW-1:0] MODE_ADDR = 8'h09
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic [NSRC-1:0] bus_wdata,
    output logic [NSRC-1:0] mask_q,
    output logic [NSRC-1:0] mode_q
);

    logic wr_mask;
    logic wr_mode;

    always_comb begin
        wr_mask = bus_wr && (bus_addr == MASK_ADDR);
        wr_mode = bus_wr && (bus_addr == MODE_ADDR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            mode_q <= '0;
        end else begin
            if (wr_mask) mask_q <= bus_wdata;
            if (wr_mode) mode_q <= bus_wdata;
        end
    end

    AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == STAT_ADDR) |=> ($stable(mask_q) && $stable(mode_q))); // R1

endmodule

// File: rtl/irq_bus_fsm.sv
module irq_bus_fsm
    import irq_pkg::*;
#(
    parameter int unsigned NSRC = 8,
    parameter int unsigned AW   = 8,
    parameter logic [AW-1:0] STAT_ADDR = 8'h07,
    parameter logic [AW-1:0] MASK_ADDR = 8'h08,
    parameter logic [AW-1:0] MODE_ADDR = 8'h09
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_rd,
    input  logic [NSRC-1:0] stat_vec,
    input  logic [NSRC-1:0] mask_q,
    input  logic [NSRC-1:0] mode_q,
    output logic            clr_stat,
    output logic [NSRC-1:0] bus_rdata
);

    bus_state_e      state_q;
    bus_state_e      state_nxt;
    logic [NSRC-1:0] rd_sel;
    logic [NSRC-1:0] rdata_q;

    always_comb begin
        unique case (bus_addr)
            STAT_ADDR: rd_sel = stat_vec;
            MASK_ADDR: rd_sel = mask_q;
            MODE_ADDR: rd_sel = mode_q;
            default:   rd_sel = '0;
        endcase
    end

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            BUS_IDLE: state_nxt = bus_rd ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_nxt = bus_rd ? BUS_RESP : BUS_IDLE;
            default:  state_nxt = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_nxt;
            rdata_q <= bus_rd ? rd_sel : '0;
        end
    end

    // output process
    always_comb begin
        clr_stat  = bus_rd && (bus_addr == STAT_ADDR);
        bus_rdata = (state_q == BUS_RESP) ? rdata_q : '0;
    end

    AST_RESP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> (state_q == BUS_RESP)); // R4
    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0)); // R11

endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs
    import irq_pkg::*;
#(
    parameter int unsigned NSRC = 8,
    parameter int unsigned AW   = 8,
    parameter logic [AW-1:0] STAT_ADDR = 8'h07,
    parameter logic [AW-1:0] MASK_ADDR = 8'h08,
    parameter logic [AW-1:0] MODE_ADDR = 8'h09
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_rd,
    input  logic            bus_wr,
    input  logic [NSRC-1:0] bus_wdata,
    output logic [NSRC-1:0] bus_rdata,
    input  logic [NSRC-1:0] src_in,
    input  logic            irq_pol,
    output logic            irq_out
);

    localparam int unsigned LAST = NSRC - 1;

    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] mode_q;
    logic [NSRC-1:0] stat_vec;
    logic            clr_stat;
    logic            irq_any;

    irq_cfg_regs #(
        .NSRC(NSRC), .AW(AW),
        .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR), .MODE_ADDR(MODE_ADDR)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .mask_q   (mask_q),
        .mode_q   (mode_q)
    );

    for (genvar i = 0; i <= LAST; i++) begin : g_cell
        irq_sticky_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .src   (src_in[i]),
            .enable(mask_q[i]),
            .level (mode_q[i]),
            .clr   (clr_stat),
            .pend_o(stat_vec[i])
        );
    end

    irq_bus_fsm #(
        .NSRC(NSRC), .AW(AW),
        .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR), .MODE_ADDR(MODE_ADDR)
    ) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .stat_vec (stat_vec),
        .mask_q   (mask_q),
        .mode_q   (mode_q),
        .clr_stat (clr_stat),
        .bus_rdata(bus_rdata)
    );

    always_comb begin
        irq_any = |stat_vec;
        irq_out = irq_pol ? irq_any : ~irq_any;
    end

    AST_IRQ_ASSERTED: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_vec != '0) |-> (irq_out == irq_pol)); // R9
    AST_STATUS_WITHIN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_vec & ~mask_q) == '0 || !$stable(mask_q))); // R6

endmodule

// File: tb/tb_irq_status_regs.sv
`timescale 1ns/1ps
module tb_irq_status_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] src_in = '0;
    logic       irq_pol = 1'b1;
    logic       irq_out;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    irq_status_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_in(src_in), .irq_pol(irq_pol), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic pulse(input logic [7:0] v);
        @(negedge clk); src_in = v;
        @(negedge clk); src_in = '0;
    endtask

    initial begin
        logic [7:0] d;
        logic [7:0] b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10 irq_out after reset", {7'd0, irq_out}, 8'h00);
        check("R11 idle rdata", bus_rdata, 8'h00);
        reg_rd(8'h07, d); check("R10 status after reset", d, 8'h00);
        reg_rd(8'h08, d); check("R6 mask reset", d, 8'h00);
        reg_rd(8'h09, d); check("R7 mode reset", d, 8'h00);
        // R6: masked sources never set
        pulse(8'hFF);
        reg_rd(8'h07, d); check("R6 masked sources", d, 8'h00);
        // R6 / R7: register sweeps
        for (int v = 0; v < 256; v++) begin
            reg_wr(8'h08, 8'(v)); reg_rd(8'h08, d); check("R6 mask readback", d, 8'(v));
            reg_wr(8'h09, 8'(v)); reg_rd(8'h09, d); check("R7 mode readback", d, 8'(v));
        end
        reg_wr(8'h08, 8'hFF);
        reg_wr(8'h09, 8'h00);
        // R3 / R2 / R4 / R9: edge mode per bit
        for (int i = 0; i < 8; i++) begin
            b = 8'(1) << i;
            pulse(b);
            check("R9 irq asserted", {7'd0, irq_out}, 8'h01);
            reg_rd(8'h07, d); check("R3 R2 edge set", d, b);
            reg_rd(8'h07, d); check("R4 cleared by read", d, 8'h00);
            check("R9 irq deasserted", {7'd0, irq_out}, 8'h00);
            @(negedge clk); src_in = b;
            reg_rd(8'h07, d); check("R3 held source sets once", d, b);
            reg_rd(8'h07, d); check("R3 no re-set while held", d, 8'h00);
            src_in = '0;
        end
        // R5: level mode per bit
        reg_wr(8'h09, 8'hFF);
        for (int i = 0; i < 8; i++) begin
            b = 8'(1) << i;
            @(negedge clk); src_in = b;
            reg_rd(8'h07, d); check("R5 level set", d, b);
            reg_rd(8'h07, d); check("R5 survives read", d, b);
            src_in = '0;
            reg_rd(8'h07, d); check("R5 still set after fall", d, b);
            reg_rd(8'h07, d); check("R5 cleared after fall", d, 8'h00);
        end
        reg_wr(8'h09, 8'h00);
        // R1: status write ignored
        pulse(8'h08);
        reg_wr(8'h07, 8'h00);
        reg_wr(8'h07, 8'hFF);
        reg_rd(8'h08, d); check("R1 mask untouched", d, 8'hFF);
        reg_rd(8'h09, d); check("R1 mode untouched", d, 8'h00);
        reg_rd(8'h07, d); check("R1 status unchanged", d, 8'h08);
        // R8: set wins over clearing read
        for (int i = 0; i < 8; i++) begin
            b = 8'(1) << i;
            pulse(b);
            @(negedge clk); bus_addr = 8'h07; bus_rd = 1'b1; src_in = b;
            @(negedge clk); bus_rd = 1'b0; src_in = '0; d = bus_rdata;
            check("R8 read returns earlier", d, b);
            reg_rd(8'h07, d); check("R8 new event kept", d, b);
            reg_rd(8'h07, d); check("R8 then cleared", d, 8'h00);
        end
        // R6: disabling clears
        pulse(8'h04);
        reg_wr(8'h08, 8'hFB);
        reg_rd(8'h07, d); check("R6 disabled bit reads 0", d, 8'h00);
        reg_wr(8'h08, 8'hFF);
        reg_rd(8'h07, d); check("R6 not revived", d, 8'h00);
        // R9: low polarity
        irq_pol = 1'b0;
        @(negedge clk);
        check("R9 low polarity idle", {7'd0, irq_out}, 8'h01);
        pulse(8'h80);
        check("R9 low polarity asserted", {7'd0, irq_out}, 8'h00);
        reg_rd(8'h07, d); check("R2 bit7", d, 8'h80);
        irq_pol = 1'b1;
        // R11: unmapped address and idle data
        pulse(8'h01);
        reg_rd(8'h20, d); check("R11 unmapped read", d, 8'h00);
        @(negedge clk);
        check("R11 idle rdata after response", bus_rdata, 8'h00);
        reg_rd(8'h07, d); check("R11 unmapped read kept status", d, 8'h01);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule